// File: doc/BRIEF.md
# USB Endpoint DMA Descriptor Completion Engine

This block serves one USB endpoint. It takes the control fields of a DMA descriptor: the largest packet size, the buffer length and the buffer start address. It then lets packet bytes pass from a valid/ready byte stream to a memory-side port, and keeps two counts as it goes: bytes placed in the buffer and bytes seen in the current USB packet. Each descriptor ends in one of three ways. When the buffer fills at a packet boundary, that is a normal completion. When a short packet closes the transfer before the buffer is full, that is an underrun. When the buffer fills in the middle of a packet, that is an overrun. On any of these ends the block builds the two descriptor words that are written back to memory, raises an end-of-transfer interrupt and waits for the write-back to be acknowledged.

An overrun clears the endpoint's DMA enable. The partly moved packet is left out of the reported count, so that it can be delivered again in full. A descriptor with a zero buffer length asks for nothing to be sent and retires at once. On bulk endpoints an optional concatenated mode lets a descriptor end inside a packet, and the next descriptor then carries on in that same packet.

Top module: `usb_dd_complete`

## Requirements
- R1: After reset, the DMA enable is 0, `dd_ready`, `s_ready`, `wb_req` and `eot_irq` are 0, and `wb_word3` is 0, which is the "not serviced" status code.
- R2: A descriptor is taken on `dd_load` only when the block is idle and the DMA enable is set. Otherwise the load is ignored and the status and write-back words keep their values. A taken descriptor with a nonzero length shows status code 1 (being serviced).
- R3: A normal completion happens when the buffer fills on the last byte of a packet. A packet ends either on `s_last` or when it reaches the largest packet size. A normal completion sets status code 2 with the count equal to the buffer length. This holds even when that packet is short.
- R4: An underrun happens when a packet ends on `s_last` shorter than the largest packet size before the buffer fills. It sets status code 3, and the count is the number of bytes moved.
- R5: An overrun happens when the buffer fills in the middle of a packet in normal mode. It sets status code 4 and clears the DMA enable. The reported count leaves out every byte of the interrupted packet, and no further byte is accepted.
- R6: `wb_word2` equals the start address plus the count. `wb_word3` holds the count in bits 31:16, the status code in bits 3:1 and the retired flag in bit 0, and the other bits are 0. The retired flag is 1 on every completion. While a descriptor runs, `m_addr` is the start address plus the bytes moved so far.
- R7: `wb_req` and `eot_irq` are one-cycle pulses that rise together. The block accepts no new descriptor until `wb_ack` arrives.
- R8: A descriptor with a zero buffer length moves no bytes. It retires at once with status code 2 and a count of 0.
- R9: A packet that reaches the largest packet size without `s_last` is complete, and the transfer continues into the next packet.
- R10: In concatenated mode on a bulk endpoint, a buffer filling mid-packet is a normal completion. The next concatenated descriptor continues in that packet, and the shortness of a packet is judged on the whole packet.
- R11: A request for concatenated mode on a non-bulk endpoint is ignored, and a mid-packet buffer end is then an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en_set | input | 1 | Pulse that sets the endpoint DMA enable |
| dma_en | output | 1 | Endpoint DMA enable |
| dd_load | input | 1 | Descriptor fields are valid this cycle |
| dd_maxpkt | input | 16 | Largest packet size; 0 means no limit |
| dd_buflen | input | 16 | Buffer length in bytes |
| dd_start | input | AW | Buffer start address |
| ep_bulk | input | 1 | The endpoint is a bulk endpoint |
| cat_req | input | 1 | Request for concatenated mode |
| dd_ready | output | 1 | Idle and enabled, so a descriptor can be loaded |
| s_valid | input | 1 | Packet byte valid |
| s_data | input | 8 | Packet byte |
| s_last | input | 1 | Last byte of a USB packet |
| s_ready | output | 1 | Packet byte accepted |
| m_valid | output | 1 | Byte for memory is valid |
| m_data | output | 8 | Byte for memory |
| m_addr | output | AW | Memory address of the byte |
| m_ready | input | 1 | Memory side can take the byte |
| wb_req | output | 1 | Write-back request strobe |
| eot_irq | output | 1 | End-of-transfer interrupt pulse |
| wb_word2 | output | AW | Written-back address word |
| wb_word3 | output | 32 | Written-back count and status word |
| wb_ack | input | 1 | Write-back done |

## Verification
The hardest state to reach is a packet that straddles two concatenated descriptors. The first descriptor has to retire mid-packet. The stream then stalls through the write-back, and the second descriptor has to resume with the partial packet length still held inside the block. The bench starts a 16-byte packet against a 12-byte buffer. After the acknowledge it reloads and sends the 4 remaining bytes ending with `s_last`. It checks that no completion follows, because the packet had reached full size. It then sends a 3-byte packet and expects an underrun with a count of 7. A block that dropped the carried length would report an underrun of 4 instead.

// File: rtl/usb_dd_complete.sv
module usb_dd_complete #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en_set,
  output logic          dma_en,
  input  logic          dd_load,
  input  logic [15:0]   dd_maxpkt,
  input  logic [15:0]   dd_buflen,
  input  logic [AW-1:0] dd_start,
  input  logic          ep_bulk,
  input  logic          cat_req,
  output logic          dd_ready,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          m_valid,
  output logic [7:0]    m_data,
  output logic [AW-1:0] m_addr,
  input  logic          m_ready,
  output logic          wb_req,
  output logic          eot_irq,
  output logic [AW-1:0] wb_word2,
  output logic [31:0]   wb_word3,
  input  logic          wb_ack
);

  localparam logic [2:0] ST_NONE = 3'd0, ST_SERV = 3'd1, ST_NORM = 3'd2,
                         ST_UNDR = 3'd3, ST_OVR  = 3'd4;

  typedef enum logic [1:0] {IDLE, RUN, WBK} phase_t;
  phase_t phase;

  logic [15:0]   maxpkt, buflen, cnt, pkt;
  logic [AW-1:0] start;
  logic          cat, retired;
  logic [2:0]    status;

  wire        take     = (phase == RUN) && s_valid && m_ready;
  wire [15:0] cnt_n    = cnt + 16'd1;
  wire [15:0] pkt_n    = pkt + 16'd1;
  wire        pkt_full = (maxpkt != 16'd0) && (pkt_n == maxpkt);
  wire        pkt_end  = s_last || pkt_full;
  wire        buf_end  = (cnt_n == buflen);

  assign dd_ready = (phase == IDLE) && dma_en;
  assign s_ready  = (phase == RUN) && m_ready;
  assign m_valid  = (phase == RUN) && s_valid;
  assign m_data   = s_data;
  assign m_addr   = start + AW'(cnt);
  assign wb_word2 = start + AW'(cnt);
  assign wb_word3 = {cnt, 12'd0, status, retired};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= IDLE;
      dma_en  <= 1'b0;
      maxpkt  <= '0;
      buflen  <= '0;
      start   <= '0;
      cnt     <= '0;
      pkt     <= '0;
      cat     <= 1'b0;
      status  <= ST_NONE;
      retired <= 1'b0;
      wb_req  <= 1'b0;
      eot_irq <= 1'b0;
    end else begin
      wb_req  <= 1'b0;
      eot_irq <= 1'b0;
      if (dma_en_set) dma_en <= 1'b1;
      unique case (phase)
        IDLE: if (dd_load && dma_en) begin
          maxpkt  <= dd_maxpkt;
          buflen  <= dd_buflen;
          start   <= dd_start;
          cat     <= cat_req && ep_bulk;
          cnt     <= '0;
          if (!(cat_req && ep_bulk)) pkt <= '0;
          if (dd_buflen == 16'd0) begin
            status  <= ST_NORM;
            retired <= 1'b1;
            wb_req  <= 1'b1;
            eot_irq <= 1'b1;
            phase   <= WBK;
          end else begin
            status  <= ST_SERV;
            retired <= 1'b0;
            phase   <= RUN;
          end
        end
        RUN: if (take) begin
          if (buf_end || (pkt_end && s_last && !pkt_full)) begin
            retired <= 1'b1;
            wb_req  <= 1'b1;
            eot_irq <= 1'b1;
            phase   <= WBK;
          end
          if (buf_end && !pkt_end && !cat) begin
            cnt    <= cnt - pkt;
            pkt    <= '0;
            status <= ST_OVR;
            dma_en <= 1'b0;
          end else begin
            cnt <= cnt_n;
            pkt <= pkt_end ? 16'd0 : pkt_n;
            if (buf_end)       status <= ST_NORM;
            else if (pkt_end && s_last && !pkt_full) status <= ST_UNDR;
          end
        end
        WBK: if (wb_ack) phase <= IDLE;
        default: phase <= IDLE;
      endcase
    end
  end

  AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |=> !wb_req); // R7
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == WBK && !wb_ack) |=> (phase == WBK && !s_ready)); // R7
  AST_WB_RETIRED: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (retired && status >= ST_NORM && status <= ST_OVR)); // R6
  AST_OVR_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && status == ST_OVR) |-> !dma_en); // R5
  AST_RUN_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == RUN) |-> (cnt < buflen)); // R8
  AST_OVR_NOT_CAT: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && status == ST_OVR) |-> !cat); // R11

endmodule

// File: tb/usb_dd_complete_bench.sv
module usb_dd_complete_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dma_en_set = 0, dd_load = 0, ep_bulk = 0, cat_req = 0;
  logic [15:0] dd_maxpkt = 0, dd_buflen = 0;
  logic [31:0] dd_start = 0;
  logic s_valid = 0, s_last = 0, m_ready = 1, wb_ack = 0;
  logic [7:0] s_data = 0;
  logic dma_en, dd_ready, s_ready, m_valid, wb_req, eot_irq;
  logic [7:0] m_data;
  logic [31:0] m_addr, wb_word2, wb_word3;

  usb_dd_complete #(.AW(32)) u_usb_dd_complete (
    .clk(clk), .rst_n(rst_n), .dma_en_set(dma_en_set), .dma_en(dma_en),
    .dd_load(dd_load), .dd_maxpkt(dd_maxpkt), .dd_buflen(dd_buflen),
    .dd_start(dd_start), .ep_bulk(ep_bulk), .cat_req(cat_req),
    .dd_ready(dd_ready), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .m_valid(m_valid), .m_data(m_data), .m_addr(m_addr),
    .m_ready(m_ready), .wb_req(wb_req), .eot_irq(eot_irq),
    .wb_word2(wb_word2), .wb_word3(wb_word3), .wb_ack(wb_ack));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    int mp; int len; int bulk; int cat; int plen; int npk; int lastf;
    int st; int cnt; int req;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8, 16, 1, 0, 8, 2, 1, 2, 16, 3},   // R3 two full packets
    '{8, 20, 1, 0, 8, 3, 1, 4, 16, 5},   // R5 buffer ends mid third packet
    '{8, 20, 1, 0, 5, 1, 1, 3, 5, 4},    // R4 short packet
    '{8, 16, 1, 0, 8, 2, 0, 2, 16, 9},   // R9 packets end by size only
    '{8, 12, 1, 1, 8, 2, 1, 2, 12, 10},  // R10 concatenated bulk
    '{8, 12, 0, 1, 8, 2, 1, 4, 8, 11},   // R11 concatenated on non-bulk
    '{8, 6, 1, 0, 6, 1, 1, 2, 6, 3},     // R3 short packet fills buffer
    '{4, 10, 1, 0, 4, 3, 1, 4, 8, 5}     // R5 overrun with small packets
  };

  int total = 0, failed = 0, wb_cnt = 0, pair_err = 0;
  logic [31:0] cap2 = 0, cap3 = 0;

  always @(negedge clk) begin
    if (eot_irq != wb_req) pair_err++;
    if (wb_req) begin
      wb_cnt++;
      cap2 = wb_word2;
      cap3 = wb_word3;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  task automatic en_pulse();
    @(negedge clk); dma_en_set = 1;
    @(negedge clk); dma_en_set = 0;
  endtask

  task automatic load(input int mp, input int len, input int bulk, input int cat,
                      input logic [31:0] addr);
    @(negedge clk);
    dd_maxpkt = 16'(mp); dd_buflen = 16'(len); ep_bulk = bulk[0]; cat_req = cat[0];
    dd_start = addr; dd_load = 1;
    @(negedge clk); dd_load = 0;
  endtask

  task automatic send_bytes(input int n, input int plen, input int lastf, output int acc);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!s_ready) begin s_valid = 0; s_last = 0; break; end
      s_valid = 1; s_data = 8'(i);
      s_last = (lastf != 0) && ((i % plen) == plen - 1);
      acc++;
      @(posedge clk);
    end
    @(negedge clk); s_valid = 0; s_last = 0;
  endtask

  task automatic wait_wb(input int prev);
    for (int k = 0; k < 6; k++) begin
      if (wb_cnt > prev) break;
      @(negedge clk);
    end
  endtask

  task automatic ack();
    @(negedge clk); wb_ack = 1;
    @(negedge clk); wb_ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int prev, acc;
    logic [31:0] sa;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 dma_en", dma_en, 0);
    chk("R1 dd_ready", dd_ready, 0);
    chk("R1 s_ready", s_ready, 0);
    chk("R1 wb_req", wb_req, 0);
    chk("R1 word3", wb_word3, 0);

    // R8 zero-length descriptor, and R7 load ignored during write-back
    en_pulse();
    prev = wb_cnt;
    load(0, 0, 1, 0, 32'h40);
    chk("R8 s_ready", s_ready, 0);
    wait_wb(prev);
    chk("R8 completed", wb_cnt, prev + 1);
    chk("R8 status", cap3[3:1], 2);
    chk("R8 count", cap3[31:16], 0);
    chk("R8 retired", cap3[0], 1);
    prev = wb_cnt;
    load(0, 0, 1, 0, 32'h80);
    repeat (3) @(negedge clk);
    chk("R7 load during write-back", wb_cnt, prev);
    chk("R7 dd_ready low", dd_ready, 0);
    ack();
    chk("R7 dd_ready after ack", dd_ready, 1);

    for (int i = 0; i < 8; i++) begin
      sa = 32'h100 * (i + 1);
      en_pulse();
      prev = wb_cnt;
      load(VECS[i].mp, VECS[i].len, VECS[i].bulk, VECS[i].cat, sa);
      chk($sformatf("R2 serviced v%0d", i), wb_word3[3:1], 1);
      send_bytes(VECS[i].plen * VECS[i].npk, VECS[i].plen, VECS[i].lastf, acc);
      wait_wb(prev);
      chk($sformatf("R%0d status v%0d", VECS[i].req, i), cap3[3:1], VECS[i].st);
      chk($sformatf("R%0d count v%0d", VECS[i].req, i), cap3[31:16], VECS[i].cnt);
      chk($sformatf("R6 word2 v%0d", i), cap2, sa + VECS[i].cnt);
      chk($sformatf("R6 retired v%0d", i), cap3[0], 1);
      if (VECS[i].st == 4) begin
        chk($sformatf("R5 enable cleared v%0d", i), dma_en, 0);
        chk($sformatf("R5 no byte taken v%0d", i), s_ready, 0);
      end
      ack();
    end

    // R2 load while disabled (last vector was an overrun)
    load(8, 16, 1, 0, 32'h900);
    @(negedge clk);
    chk("R2 disabled load status", wb_word3[3:1], 4);
    chk("R2 disabled s_ready", s_ready, 0);
    chk("R2 disabled dd_ready", dd_ready, 0);

    // R10 packet carried across concatenated descriptors
    en_pulse();
    prev = wb_cnt;
    load(8, 12, 1, 1, 32'h2000);
    chk("R6 m_addr at start", m_addr, 32'h2000);
    send_bytes(16, 16, 1, acc);
    wait_wb(prev);
    chk("R10 bytes taken", acc, 12);
    chk("R10 first status", cap3[3:1], 2);
    chk("R10 first count", cap3[31:16], 12);
    ack();
    prev = wb_cnt;
    load(8, 16, 1, 1, 32'h3000);
    send_bytes(4, 4, 1, acc);
    repeat (3) @(negedge clk);
    chk("R10 full packet continues", wb_cnt, prev);
    chk("R6 m_addr mid", m_addr, 32'h3004);
    send_bytes(3, 3, 1, acc);
    wait_wb(prev);
    chk("R10 second status", cap3[3:1], 3);
    chk("R10 second count", cap3[31:16], 7);
    chk("R6 second word2", cap2, 32'h3007);
    ack();

    chk("R7 irq paired with wb_req", pair_err, 0);
    report();
  end
endmodule